// File: doc/BRIEF.md
# Register Subaddress Pointer with Bus Gating

This block sits behind a byte-level two-wire serial slave front end. That front end handles start and stop detection and the bit-level protocol. It hands this block a start strobe, a stop strobe, a write-byte strobe with its data, and a read-byte acknowledge. The first byte written after a start is a control byte. It loads a 5-bit register pointer and an auto-increment disable flag. It also sets a permanent gate bit and a one-shot short-gate bit for a downstream secondary bus. Each later write byte lands in a 32-slot register space at the pointer. Each written or read byte then moves the pointer on by fixed wrap rules.

Only slots 0x00 to 0x13 and slot 0x1F hold storage. The other slots ignore writes and read as zero. All stored registers are presented in parallel to the processing logic behind the block. A single enable output gates the secondary bus outputs. It is high while the permanent gate bit is set, while a short gate is pending or running, or while an external autogate request is raised.

Top module: `subaddr_gate_top`

## Requirements
- R1: After reset the pointer is 0, auto-increment is on, both gate bits are 0, every register reads 0x00, and `gate_en_o` equals `autogate_req_i`.
- R2: The first write byte after a start is a control byte, and it writes no register. Bits 4:0 load the pointer. Bit 7 set to 1 turns auto-increment off. Bit 6 is the permanent gate bit. Bit 5 requests a short gate.
- R3: A later write byte is stored in the register the pointer names when that slot is implemented. The byte then reads back from the slot and appears on `regs_o[8*a +: 8]`.
- R4: With auto-increment on, each data write or read byte moves the pointer up by one. From 30 the pointer goes to 0.
- R5: The pointer reaches 31 only through a control byte. A step taken from 31 goes to 0.
- R6: With auto-increment off, the pointer holds. Every data byte of the transaction goes to the same register, and reads repeat that register.
- R7: Writes to slots 0x14 to 0x1E are discarded, and reads from them return 0x00.
- R8: While the permanent gate bit is 1, `gate_en_o` is 1 across transactions. A later control byte with bit 6 at 0 clears the bit.
- R9: A short gate drives `gate_en_o` high from its control byte until the stop that ends the next transaction. It is cleared there, not at the stop of its own transaction.
- R10: `gate_en_o` is the OR of the permanent gate bit, the short-gate state and `autogate_req_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start condition seen (one cycle) |
| stop_i | input | 1 | Stop condition seen (one cycle) |
| wr_valid_i | input | 1 | A write byte is present on wr_data_i |
| wr_data_i | input | 8 | Write byte |
| rd_ack_i | input | 1 | The byte on rd_data_o has been sent to the master |
| rd_data_o | output | 8 | Register at the current pointer |
| regs_o | output | 256 | All 32 slots, slot a at bits 8*a+7:8*a |
| autogate_req_i | input | 1 | External request to open the secondary bus |
| gate_en_o | output | 1 | Enable for the secondary bus data and clock outputs |

## Verification
The checker watches the pointer on every cycle. It checks stepping by one, the wrap from 30 and from 31 to 0, and the hold when auto-increment is off. It also checks that 31 is entered only by a control byte and that unimplemented slots read zero. On every cycle it confirms that the gate bit and the autogate request each force the enable high. It also checks that a running short gate falls at a stop. The bench scenarios are needed to show the data path end to end: control bytes consuming no register, written values coming back on reads and on the parallel bus, and discarded writes. They also show the short gate lasting across exactly one following transaction, and the permanent gate outliving transactions until it is cleared.

// File: rtl/subaddr_gate_pkg.sv
package subaddr_gate_pkg;
    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 5;
    localparam int NUM_SLOTS = 1 << ADDR_W;
    localparam int WRAP_TOP  = NUM_SLOTS - 2;   // 30: last auto-reachable slot
    localparam int LAST_LOW  = 19;              // 0x13: last of the low block
    localparam int AGATE_SLOT = NUM_SLOTS - 1;  // 31: direct-only slot

    typedef logic [ADDR_W-1:0] slot_t;
    typedef logic [DATA_W-1:0] byte_t;

    // Control byte layout: bit7 no-increment, bit6 gate, bit5 short gate, 4:0 slot
    typedef struct packed {
        logic  no_inc;
        logic  gate;
        logic  short_gate;
        slot_t sel;
    } ctl_byte_t;

    typedef enum logic [1:0] {
        SG_IDLE   = 2'd0,
        SG_ARMED  = 2'd1,   // requested, own transaction still open
        SG_ACTIVE = 2'd2    // running through the following transaction
    } sg_state_t;

    function automatic slot_t step_slot(input slot_t p);
        if (int'(p) >= WRAP_TOP) return '0;
        return p + slot_t'(1);
    endfunction

    function automatic logic slot_present(input int a);
        return (a <= LAST_LOW) || (a == AGATE_SLOT);
    endfunction
endpackage

// File: rtl/subaddr_pointer.sv
module subaddr_pointer
    import subaddr_gate_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start_i,
    input  logic      stop_i,
    input  logic      wr_valid_i,
    input  byte_t     wr_data_i,
    input  logic      rd_ack_i,
    output slot_t     ptr_o,
    output logic      no_inc_o,
    output logic      ctl_wr_o,
    output logic      data_wr_o,
    output ctl_byte_t ctl_o
);
    logic  want_ctl_q;
    slot_t ptr_q;
    logic  no_inc_q;

    assign ctl_o     = ctl_byte_t'(wr_data_i);
    assign ctl_wr_o  = wr_valid_i && want_ctl_q;
    assign data_wr_o = wr_valid_i && !want_ctl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            want_ctl_q <= 1'b1;
        end else if (start_i || stop_i) begin
            want_ctl_q <= 1'b1;
        end else if (wr_valid_i) begin
            want_ctl_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q    <= '0;
            no_inc_q <= 1'b0;
        end else if (ctl_wr_o) begin
            ptr_q    <= ctl_o.sel;
            no_inc_q <= ctl_o.no_inc;
        end else if ((data_wr_o || rd_ack_i) && !no_inc_q) begin
            ptr_q    <= step_slot(ptr_q);
        end
    end

    assign ptr_o    = ptr_q;
    assign no_inc_o = no_inc_q;
endmodule

// File: rtl/subaddr_regbank.sv
module subaddr_regbank
    import subaddr_gate_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en_i,
    input  slot_t                       wr_slot_i,
    input  byte_t                       wr_data_i,
    input  slot_t                       rd_slot_i,
    output byte_t                       rd_data_o,
    output logic [NUM_SLOTS*DATA_W-1:0] regs_o
);
    byte_t slots [NUM_SLOTS];

    for (genvar a = 0; a < NUM_SLOTS; a++) begin : g_slot
        if (slot_present(a)) begin : g_store
            byte_t q;
            always_ff @(posedge clk) begin
                if (rst)                                  q <= '0;
                else if (wr_en_i && wr_slot_i == slot_t'(a)) q <= wr_data_i;
            end
            assign slots[a] = q;
        end else begin : g_empty
            assign slots[a] = '0;
        end
        assign regs_o[a*DATA_W +: DATA_W] = slots[a];
    end

    assign rd_data_o = slots[rd_slot_i];
endmodule

// File: rtl/subaddr_gate_unit.sv
module subaddr_gate_unit
    import subaddr_gate_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ctl_wr_i,
    input  ctl_byte_t ctl_i,
    input  logic      stop_i,
    input  logic      autogate_req_i,
    output logic      gate_o,
    output sg_state_t sg_o,
    output logic      gate_en_o
);
    logic      gate_q;
    sg_state_t sg_q;

    always_ff @(posedge clk) begin
        if (rst)           gate_q <= 1'b0;
        else if (ctl_wr_i) gate_q <= ctl_i.gate;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sg_q <= SG_IDLE;
        end else if (ctl_wr_i && ctl_i.short_gate) begin
            sg_q <= SG_ARMED;
        end else if (stop_i) begin
            unique case (sg_q)
                SG_ARMED:  sg_q <= SG_ACTIVE;
                SG_ACTIVE: sg_q <= SG_IDLE;
                default:   sg_q <= SG_IDLE;
            endcase
        end
    end

    assign gate_o    = gate_q;
    assign sg_o      = sg_q;
    assign gate_en_o = gate_q || (sg_q != SG_IDLE) || autogate_req_i;
endmodule

// File: rtl/subaddr_gate_top.sv
module subaddr_gate_top
    import subaddr_gate_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic         stop_i,
    input  logic         wr_valid_i,
    input  logic [7:0]   wr_data_i,
    input  logic         rd_ack_i,
    output logic [7:0]   rd_data_o,
    output logic [255:0] regs_o,
    input  logic         autogate_req_i,
    output logic         gate_en_o
);
    slot_t     ptr_w;
    logic      no_inc_w;
    logic      ctl_wr_w;
    logic      data_wr_w;
    ctl_byte_t ctl_w;
    logic      gate_w;
    sg_state_t sg_w;

    subaddr_pointer u_ptr (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .stop_i     (stop_i),
        .wr_valid_i (wr_valid_i),
        .wr_data_i  (wr_data_i),
        .rd_ack_i   (rd_ack_i),
        .ptr_o      (ptr_w),
        .no_inc_o   (no_inc_w),
        .ctl_wr_o   (ctl_wr_w),
        .data_wr_o  (data_wr_w),
        .ctl_o      (ctl_w)
    );

    subaddr_regbank u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (data_wr_w),
        .wr_slot_i (ptr_w),
        .wr_data_i (wr_data_i),
        .rd_slot_i (ptr_w),
        .rd_data_o (rd_data_o),
        .regs_o    (regs_o)
    );

    subaddr_gate_unit u_gate (
        .clk            (clk),
        .rst            (rst),
        .ctl_wr_i       (ctl_wr_w),
        .ctl_i          (ctl_w),
        .stop_i         (stop_i),
        .autogate_req_i (autogate_req_i),
        .gate_o         (gate_w),
        .sg_o           (sg_w),
        .gate_en_o      (gate_en_o)
    );
endmodule

// File: rtl/subaddr_gate_chk.sv
module subaddr_gate_chk
    import subaddr_gate_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      stop_i,
    input logic      wr_valid_i,
    input logic [7:0] wr_data_i,
    input logic      rd_ack_i,
    input logic [7:0] rd_data_o,
    input logic      autogate_req_i,
    input logic      gate_en_o,
    input slot_t     ptr_w,
    input logic      no_inc_w,
    input logic      ctl_wr_w,
    input logic      data_wr_w,
    input logic      gate_w,
    input sg_state_t sg_w
);
    logic stepping;
    assign stepping = (data_wr_w || rd_ack_i) && !no_inc_w && !ctl_wr_w;

    assert_step_R4: assert property (@(posedge clk) disable iff (rst)
        stepping && int'(ptr_w) < WRAP_TOP |=> ptr_w == $past(ptr_w) + slot_t'(1));

    assert_wrap30_R4: assert property (@(posedge clk) disable iff (rst)
        stepping && int'(ptr_w) == WRAP_TOP |=> ptr_w == '0);

    assert_wrap31_R5: assert property (@(posedge clk) disable iff (rst)
        stepping && int'(ptr_w) == AGATE_SLOT |=> ptr_w == '0);

    assert_direct31_R5: assert property (@(posedge clk) disable iff (rst)
        int'(ptr_w) != AGATE_SLOT && !(ctl_wr_w && int'(wr_data_i[4:0]) == AGATE_SLOT)
        |=> int'(ptr_w) != AGATE_SLOT);

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (data_wr_w || rd_ack_i) && no_inc_w && !ctl_wr_w |=> $stable(ptr_w));

    assert_empty_R7: assert property (@(posedge clk) disable iff (rst)
        int'(ptr_w) > LAST_LOW && int'(ptr_w) < AGATE_SLOT |-> rd_data_o == 8'h00);

    assert_gate_R8: assert property (@(posedge clk) disable iff (rst)
        gate_w |-> gate_en_o);

    assert_sg_end_R9: assert property (@(posedge clk) disable iff (rst)
        stop_i && sg_w == SG_ACTIVE && !ctl_wr_w |=> sg_w == SG_IDLE);

    assert_agate_R10: assert property (@(posedge clk) disable iff (rst)
        autogate_req_i |-> gate_en_o);

    assert_closed_R10: assert property (@(posedge clk) disable iff (rst)
        !gate_w && sg_w == SG_IDLE && !autogate_req_i |-> !gate_en_o);

    logic unused_ok;
    assign unused_ok = wr_valid_i;
endmodule

bind subaddr_gate_top subaddr_gate_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .stop_i         (stop_i),
    .wr_valid_i     (wr_valid_i),
    .wr_data_i      (wr_data_i),
    .rd_ack_i       (rd_ack_i),
    .rd_data_o      (rd_data_o),
    .autogate_req_i (autogate_req_i),
    .gate_en_o      (gate_en_o),
    .ptr_w          (ptr_w),
    .no_inc_w       (no_inc_w),
    .ctl_wr_w       (ctl_wr_w),
    .data_wr_w      (data_wr_w),
    .gate_w         (gate_w),
    .sg_w           (sg_w)
);

// File: tb/subaddr_gate_top_tb.sv
`timescale 1ns/100ps
module subaddr_gate_top_tb;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 0, stop_i = 0, wr_valid_i = 0, rd_ack_i = 0;
    logic [7:0]   wr_data_i = '0;
    logic [7:0]   rd_data_o;
    logic [255:0] regs_o;
    logic         autogate_req_i = 0;
    logic         gate_en_o;

    int tests = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    subaddr_gate_top u_dut (.*);

    // reference state built from the requirements
    logic [7:0] m_mem [32];
    logic [4:0] m_ptr;
    logic       m_noinc;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    function automatic logic present(input logic [4:0] a);
        return (a <= 5'd19) || (a == 5'd31);
    endfunction
    function automatic logic [4:0] nxt(input logic [4:0] a);
        return (a >= 5'd30) ? 5'd0 : a + 5'd1;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic s, input logic p, input logic wv,
                       input logic [7:0] wd, input logic ra);
        @(posedge clk); #1;
        start_i = s; stop_i = p; wr_valid_i = wv; wr_data_i = wd; rd_ack_i = ra;
    endtask
    task automatic idle(); cyc(0, 0, 0, 8'h00, 0); endtask
    task automatic start(); cyc(1, 0, 0, 8'h00, 0); endtask
    task automatic stop(); cyc(0, 1, 0, 8'h00, 0); endtask

    task automatic ctl(input logic [7:0] b);
        cyc(0, 0, 1, b, 0);
        m_ptr = b[4:0]; m_noinc = b[7];
    endtask
    task automatic wdata(input logic [7:0] b);
        cyc(0, 0, 1, b, 0);
        if (present(m_ptr)) m_mem[m_ptr] = b;
        if (!m_noinc) m_ptr = nxt(m_ptr);
    endtask
    task automatic rbyte(input string tag);
        exp_q.push_back(present(m_ptr) ? m_mem[m_ptr] : 8'h00);
        tag_q.push_back(tag);
        cyc(0, 0, 0, 8'h00, 1);
        if (!m_noinc) m_ptr = nxt(m_ptr);
    endtask

    // monitor: compare each acknowledged read byte against the scoreboard
    always @(negedge clk) begin
        if (!rst && rd_ack_i) begin
            if (exp_q.size() == 0) begin
                check("R3 unexpected read", 32'(rd_data_o), 32'hFFFF);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(t, 32'(rd_data_o), 32'(e));
            end
        end
    end

    task automatic gate_chk(input string tag, input logic exp);
        idle();
        @(negedge clk);
        check(tag, 32'(gate_en_o), 32'(exp));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) m_mem[i] = 8'h00;
        m_ptr = 5'd0; m_noinc = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R1: reset state
        @(negedge clk);
        check("R1 gate_en after reset", 32'(gate_en_o), 32'h0);
        check("R1 regs after reset", 32'(regs_o == '0), 32'h1);
        start(); rbyte("R1 slot0 reset value"); rbyte("R1 step after reset"); stop();

        // R2/R3/R4: control then data from slot 0
        start(); ctl(8'h00); wdata(8'h11); wdata(8'h22); wdata(8'h33); stop();
        start(); ctl(8'h00); stop();
        start(); rbyte("R3 slot0"); rbyte("R3 slot1"); rbyte("R3 slot2");
        rbyte("R2 slot3 untouched by control"); stop();

        // R7: writes across the top of the low block
        start(); ctl(8'h12); wdata(8'hA1); wdata(8'hA2); wdata(8'hA3); stop();
        start(); ctl(8'h12); rbyte("R3 slot18"); rbyte("R3 slot19");
        rbyte("R7 slot20 reads zero"); stop();

        // R4: wrap 30 -> 0
        start(); ctl(8'h1E); wdata(8'h5A); wdata(8'hC3); stop();
        start(); ctl(8'h1D); rbyte("R7 slot29"); rbyte("R7 slot30");
        rbyte("R4 wrap to slot0"); stop();

        // R5: direct 31, wrap 31 -> 0
        start(); ctl(8'h1F); wdata(8'h7E); wdata(8'h44); stop();
        start(); ctl(8'h1F); rbyte("R5 slot31"); rbyte("R5 wrap 31 to 0"); stop();
        idle(); @(negedge clk);
        check("R3 regs_o slot31", 32'(regs_o[31*8 +: 8]), 32'h7E);
        check("R3 regs_o slot18", 32'(regs_o[18*8 +: 8]), 32'hA1);

        // R6: no auto-increment
        start(); ctl(8'h85); wdata(8'h01); wdata(8'h02); wdata(8'h03); stop();
        start(); ctl(8'h05); rbyte("R6 slot5 last"); rbyte("R6 slot6 untouched"); stop();
        start(); ctl(8'h85); rbyte("R6 repeat a"); rbyte("R6 repeat b"); stop();

        // R8: permanent gate
        start(); ctl(8'h40); stop();
        gate_chk("R8 gate on", 1'b1);
        start(); ctl(8'h0A); wdata(8'h99); stop();
        gate_chk("R8 gate keeps across transaction? cleared by bit6=0", 1'b0);
        start(); ctl(8'h40); stop();
        start(); rbyte("R8 read while gated"); stop();
        gate_chk("R8 gate persists", 1'b1);
        start(); ctl(8'h00); stop();
        gate_chk("R8 gate cleared", 1'b0);

        // R9: short gate
        start(); ctl(8'h20);
        gate_chk("R9 armed on control", 1'b1);
        stop();
        gate_chk("R9 held after own stop", 1'b1);
        start(); rbyte("R9 read in gated txn");
        gate_chk("R9 held in next txn", 1'b1);
        stop();
        gate_chk("R9 cleared after next stop", 1'b0);

        // R10: autogate request
        autogate_req_i = 1'b1;
        gate_chk("R10 autogate on", 1'b1);
        autogate_req_i = 1'b0;
        gate_chk("R10 autogate off", 1'b0);

        idle(); idle();
        check("R3 scoreboard drained", 32'(exp_q.size()), 32'h0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule